// File: doc/BRIEF.md
# Error Logging and Notification Router

This block keeps a sticky record of error events reported by one functional unit and turns each newly recorded error into a one-cycle pulse on one of four system notification outputs. The outputs are system error, system management interrupt, system control interrupt and machine check. Each of the `NTYPE` error types owns three log positions: a first-occurrence bit, a repeat-occurrence bit and a mask bit. It also owns one enable bit in each of four routing registers. A type's log bits sit at positions `LOG_BASE + k` of the 32-bit log registers. Its mask and routing bits sit at position `k`. With the defaults, routing bit 7 therefore pairs with log bit 31.

The first event of a type sets its first-occurrence bit. Any event while that bit is set goes to the repeat-occurrence bit. A notification is triggered on the rising edge of the OR of the two log bits, so a burst of repeats after the first event raises nothing new. The type must be unmasked, and the notification goes out on the output whose routing bit is set. The system error path also needs the global enable input, and it sets a sticky signalled-system-error flag.

Software reaches the registers through a single-cycle write port and a combinational read port. Log bits and the flag clear only by writing one to them. The detection logic that produces the events is outside this block.

Top module: `err_signal_router`

## Requirements
- R1: A synchronous active-low reset clears both log registers, all four routing registers and the flag, sets every mask bit to 1, and leaves all four pulse outputs low.
- R2: An event on `err_evt[k]` while first-log bit `LOG_BASE+k` is clear sets that bit at the next clock edge and leaves the repeat-log register unchanged.
- R3: An event on `err_evt[k]` while first-log bit `LOG_BASE+k` is set sets repeat-log bit `LOG_BASE+k`.
- R4: Logging happens whatever the mask and routing bits hold.
- R5: A notification pulse is exactly one cycle long. It is visible in the cycle that follows the edge at which the combined log bit of a type goes from 0 to 1. An event that finds the combined bit already at 1 produces no pulse.
- R6: A type whose mask bit is 1 produces no pulse on any output.
- R7: The system-error output pulses only when `serr_global_en` is 1. If a type selects the system-error route while the global enable is 0, that type produces no pulse on any output.
- R8: When several routing bits are set for one type, exactly one output pulses, chosen in the order system error > machine check > management interrupt > control interrupt.
- R9: A system-error pulse sets `sse_flag` at the clock edge that ends the pulse. The flag stays set until a write with bit 0 = 1 to the status register.
- R10: Writing 1 to a log bit clears it, and writing 0 has no effect. An event in the same cycle as a clear is never lost: if the first bit was set, the repeat bit is set instead. A type cleared back to 0 logs and pulses again on its next event.
- R11: Pulses from different types that trigger in the same cycle combine by OR on each output.
- R12: The register map is: address 0 first log, 1 repeat log, 2 mask, 3 system-error routing, 4 management-interrupt routing, 5 control-interrupt routing, 6 machine-check routing, 7 status (flag in bit 0). Mask and routing bits occupy bits `[NTYPE-1:0]`, and every unused read bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| err_evt | input | NTYPE | One-cycle error event per type |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address for read and write |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Combinational read data at `reg_addr` |
| serr_global_en | input | 1 | Global enable for the system-error output |
| sse_flag | output | 1 | Sticky signalled-system-error flag |
| serr_pulse | output | 1 | System error notification pulse |
| smi_pulse | output | 1 | Management interrupt notification pulse |
| sci_pulse | output | 1 | Control interrupt notification pulse |
| mcerr_pulse | output | 1 | Machine check notification pulse |

## Verification
A corrupted log bit is visible on the read port at once. It also shows on the pulse outputs one cycle after the bad edge: either a spurious pulse, or a missing pulse when the stored edge reference is stale. A wrong routing choice sends the pulse to the wrong output in the same cycle as the expected pulse. The bench sweeps every type against every single route, with the global enable both on and off, and then drives all sixteen routing combinations on one type. A fault in the flag register shows one cycle after a system-error pulse, and it stays visible until software clears the flag.

// File: rtl/err_route_pkg.sv
package err_route_pkg;

  typedef enum logic [2:0] {
    RA_FIRST = 3'd0,
    RA_NEXT  = 3'd1,
    RA_MASK  = 3'd2,
    RA_SERR  = 3'd3,
    RA_SMI   = 3'd4,
    RA_SCI   = 3'd5,
    RA_MCERR = 3'd6,
    RA_STAT  = 3'd7
  } reg_addr_e;

  typedef struct packed {
    logic serr;
    logic mcerr;
    logic smi;
    logic sci;
  } route_t;

  // Fixed precedence when software enables several routes for one type (R8)
  function automatic route_t pick_route(input logic en_serr, input logic en_mcerr,
                                        input logic en_smi, input logic en_sci);
    route_t r;
    r = '0;
    if (en_serr)       r.serr  = 1'b1;
    else if (en_mcerr) r.mcerr = 1'b1;
    else if (en_smi)   r.smi   = 1'b1;
    else if (en_sci)   r.sci   = 1'b1;
    return r;
  endfunction

  // Place a per-type vector at its log-register offset
  function automatic logic [31:0] place_log(input logic [31:0] v, input int unsigned base);
    return v << base;
  endfunction

endpackage

// File: rtl/err_log_bank.sv
module err_log_bank #(
  parameter int NTYPE = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NTYPE-1:0] evt,
  input  logic [NTYPE-1:0] clr_first,
  input  logic [NTYPE-1:0] clr_next,
  output logic [NTYPE-1:0] first_q,
  output logic [NTYPE-1:0] next_q,
  output logic [NTYPE-1:0] rise
);

  logic [NTYPE-1:0] seen_d;

  for (genvar k = 0; k < NTYPE; k++) begin : g_type
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        first_q[k] <= 1'b0;
        next_q[k]  <= 1'b0;
        seen_d[k]  <= 1'b0;
      end else begin
        if (evt[k] && !first_q[k])  first_q[k] <= 1'b1;
        else if (clr_first[k])      first_q[k] <= 1'b0;
        if (evt[k] && first_q[k])   next_q[k]  <= 1'b1;
        else if (clr_next[k])       next_q[k]  <= 1'b0;
        seen_d[k] <= first_q[k] | next_q[k];
      end
    end
  end

  assign rise = (first_q | next_q) & ~seen_d;

  AST_NEXT_NEEDS_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    ((next_q & ~$past(next_q)) & ~$past(first_q)) == '0); // R3

  AST_RISE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (rise & $past(rise)) == '0); // R5

  AST_FIRST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(first_q) & ~first_q) & ~$past(clr_first)) == '0); // R10

endmodule

// File: rtl/err_router.sv
module err_router
  import err_route_pkg::*;
#(
  parameter int NTYPE = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NTYPE-1:0] rise,
  input  logic [NTYPE-1:0] mask,
  input  logic [NTYPE-1:0] en_serr,
  input  logic [NTYPE-1:0] en_mcerr,
  input  logic [NTYPE-1:0] en_smi,
  input  logic [NTYPE-1:0] en_sci,
  input  logic             serr_global_en,
  output logic             serr_pulse,
  output logic             mcerr_pulse,
  output logic             smi_pulse,
  output logic             sci_pulse
);

  logic [NTYPE-1:0] live;
  logic [NTYPE-1:0] hit_serr, hit_mcerr, hit_smi, hit_sci;

  assign live = rise & ~mask;

  for (genvar k = 0; k < NTYPE; k++) begin : g_route
    route_t sel;
    always_comb begin
      sel = pick_route(en_serr[k], en_mcerr[k], en_smi[k], en_sci[k]);
      hit_serr[k]  = live[k] & sel.serr & serr_global_en;
      hit_mcerr[k] = live[k] & sel.mcerr;
      hit_smi[k]   = live[k] & sel.smi;
      hit_sci[k]   = live[k] & sel.sci;
    end

    AST_ONE_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({hit_serr[k], hit_mcerr[k], hit_smi[k], hit_sci[k]})); // R8
  end

  assign serr_pulse  = |hit_serr;
  assign mcerr_pulse = |hit_mcerr;
  assign smi_pulse   = |hit_smi;
  assign sci_pulse   = |hit_sci;

  AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (live == '0) |-> !(serr_pulse | mcerr_pulse | smi_pulse | sci_pulse)); // R6

  AST_SERR_NEEDS_GLOBAL: assert property (@(posedge clk) disable iff (!rst_n)
    serr_pulse |-> serr_global_en); // R7

endmodule

// File: rtl/err_signal_router.sv
module err_signal_router
  import err_route_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int NTYPE    = 8,
  parameter int LOG_BASE = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NTYPE-1:0]  err_evt,
  input  logic              reg_wr,
  input  logic [2:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              serr_global_en,
  output logic              sse_flag,
  output logic              serr_pulse,
  output logic              smi_pulse,
  output logic              sci_pulse,
  output logic              mcerr_pulse
);

  localparam int TOP_BIT = LOG_BASE + NTYPE - 1;

  initial begin
    if (TOP_BIT >= DATA_W) $error("log field does not fit the data width");
  end

  logic [NTYPE-1:0] mask_q, serr_q, smi_q, sci_q, mcerr_q;
  logic [NTYPE-1:0] first_q, next_q, rise;
  logic [NTYPE-1:0] clr_first, clr_next;
  logic             wr_first, wr_next, wr_stat;

  assign wr_first  = reg_wr && (reg_addr == RA_FIRST);
  assign wr_next   = reg_wr && (reg_addr == RA_NEXT);
  assign wr_stat   = reg_wr && (reg_addr == RA_STAT);
  assign clr_first = wr_first ? reg_wdata[LOG_BASE +: NTYPE] : '0;
  assign clr_next  = wr_next  ? reg_wdata[LOG_BASE +: NTYPE] : '0;

  err_log_bank #(.NTYPE(NTYPE)) u_log (
    .clk(clk), .rst_n(rst_n), .evt(err_evt),
    .clr_first(clr_first), .clr_next(clr_next),
    .first_q(first_q), .next_q(next_q), .rise(rise)
  );

  err_router #(.NTYPE(NTYPE)) u_route (
    .clk(clk), .rst_n(rst_n), .rise(rise), .mask(mask_q),
    .en_serr(serr_q), .en_mcerr(mcerr_q), .en_smi(smi_q), .en_sci(sci_q),
    .serr_global_en(serr_global_en),
    .serr_pulse(serr_pulse), .mcerr_pulse(mcerr_pulse),
    .smi_pulse(smi_pulse), .sci_pulse(sci_pulse)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q  <= '1;
      serr_q  <= '0;
      smi_q   <= '0;
      sci_q   <= '0;
      mcerr_q <= '0;
    end else if (reg_wr) begin
      case (reg_addr)
        RA_MASK:  mask_q  <= reg_wdata[NTYPE-1:0];
        RA_SERR:  serr_q  <= reg_wdata[NTYPE-1:0];
        RA_SMI:   smi_q   <= reg_wdata[NTYPE-1:0];
        RA_SCI:   sci_q   <= reg_wdata[NTYPE-1:0];
        RA_MCERR: mcerr_q <= reg_wdata[NTYPE-1:0];
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                      sse_flag <= 1'b0;
    else if (serr_pulse)             sse_flag <= 1'b1;
    else if (wr_stat && reg_wdata[0]) sse_flag <= 1'b0;
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      RA_FIRST: reg_rdata[LOG_BASE +: NTYPE] = first_q;
      RA_NEXT:  reg_rdata[LOG_BASE +: NTYPE] = next_q;
      RA_MASK:  reg_rdata[NTYPE-1:0] = mask_q;
      RA_SERR:  reg_rdata[NTYPE-1:0] = serr_q;
      RA_SMI:   reg_rdata[NTYPE-1:0] = smi_q;
      RA_SCI:   reg_rdata[NTYPE-1:0] = sci_q;
      RA_MCERR: reg_rdata[NTYPE-1:0] = mcerr_q;
      default:  reg_rdata[0] = sse_flag;
    endcase
  end

  AST_SSE_AFTER_SERR: assert property (@(posedge clk) disable iff (!rst_n)
    serr_pulse |=> sse_flag); // R9

  AST_SSE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sse_flag) |-> $past(wr_stat)); // R9

  AST_EVENT_LOGGED: assert property (@(posedge clk) disable iff (!rst_n)
    (err_evt != '0) |=> ((first_q | next_q) & $past(err_evt)) == $past(err_evt)); // R4

endmodule

// File: tb/sim_err_signal_router.sv
module sim_err_signal_router;
  localparam int DATA_W = 32;
  localparam int NTYPE  = 8;
  localparam int LB     = 24;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NTYPE-1:0] err_evt = '0;
  logic reg_wr = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [DATA_W-1:0] reg_wdata = '0;
  logic [DATA_W-1:0] reg_rdata;
  logic serr_global_en = 1'b0;
  logic sse_flag, serr_pulse, smi_pulse, sci_pulse, mcerr_pulse;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  err_signal_router #(.DATA_W(DATA_W), .NTYPE(NTYPE), .LOG_BASE(LB)) u0 (
    .clk(clk), .rst_n(rst_n), .err_evt(err_evt), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .serr_global_en(serr_global_en), .sse_flag(sse_flag),
    .serr_pulse(serr_pulse), .smi_pulse(smi_pulse),
    .sci_pulse(sci_pulse), .mcerr_pulse(mcerr_pulse)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    tick();
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd_reg(input logic [2:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  function automatic logic [3:0] pulses();
    return {serr_pulse, mcerr_pulse, smi_pulse, sci_pulse};
  endfunction

  // Bench view of precedence: {serr, mcerr, smi, sci}
  function automatic logic [3:0] expect_route(input logic s, input logic m, input logic i,
                                              input logic c, input logic g);
    if (s) return {g, 3'b000};
    if (m) return 4'b0100;
    if (i) return 4'b0010;
    if (c) return 4'b0001;
    return 4'b0000;
  endfunction

  task automatic clear_all();
    wr_reg(3'd0, 32'hFFFF_FFFF);
    wr_reg(3'd1, 32'hFFFF_FFFF);
    wr_reg(3'd7, 32'h1);
    tick();
  endtask

  task automatic fire(input logic [NTYPE-1:0] v);
    err_evt = v;
    tick();
    err_evt = '0;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    logic [31:0] d;
    logic [3:0] ev;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset values, R12 map and unused bits
    rd_reg(3'd0, d); chk("R1 first log", d, 32'h0);
    rd_reg(3'd1, d); chk("R1 next log", d, 32'h0);
    rd_reg(3'd2, d); chk("R1 mask all set", d, 32'h0000_00FF);
    for (int a = 3; a < 7; a++) begin
      rd_reg(3'(a), d); chk("R1 routing cleared", d, 32'h0);
    end
    rd_reg(3'd7, d); chk("R1 status", d, 32'h0);
    chk("R1 pulses low", {28'h0, pulses()}, 32'h0);

    // Sweep: every type, every single route, global enable off and on
    for (int k = 0; k < NTYPE; k++) begin
      for (int r = 0; r < 5; r++) begin
        for (int g = 0; g < 2; g++) begin
          clear_all();
          serr_global_en = g[0];
          for (int a = 3; a < 7; a++) wr_reg(3'(a), 32'h0);
          if (r > 0) wr_reg(3'(r + 2), 32'(1) << k);
          wr_reg(3'd2, ~(32'(1) << k));
          ev = expect_route(r == 1, r == 4, r == 2, r == 3, g[0]);
          fire(NTYPE'(1) << k);
          chk("R5 R7 route pulse", {28'h0, pulses()}, {28'h0, ev});
          rd_reg(3'd0, d); chk("R2 first bit set", d, 32'(1) << (LB + k));
          rd_reg(3'd1, d); chk("R2 next untouched", d, 32'h0);
          tick();
          chk("R5 pulse one cycle", {28'h0, pulses()}, 32'h0);
          chk("R9 flag", {31'h0, sse_flag}, {31'h0, ev[3]});
          fire(NTYPE'(1) << k);
          chk("R5 repeat no pulse", {28'h0, pulses()}, 32'h0);
          rd_reg(3'd1, d); chk("R3 next bit set", d, 32'(1) << (LB + k));
        end
      end
    end

    // R8 all sixteen routing combinations on type 2
    serr_global_en = 1'b1;
    for (int c = 0; c < 16; c++) begin
      clear_all();
      wr_reg(3'd3, c[3] ? 32'h4 : 32'h0);
      wr_reg(3'd6, c[2] ? 32'h4 : 32'h0);
      wr_reg(3'd4, c[1] ? 32'h4 : 32'h0);
      wr_reg(3'd5, c[0] ? 32'h4 : 32'h0);
      wr_reg(3'd2, 32'hFB);
      fire(8'h04);
      chk("R8 precedence", {28'h0, pulses()},
          {28'h0, expect_route(c[3], c[2], c[1], c[0], 1'b1)});
      tick();
    end

    // R9 flag sticky until written with 1; writing 0 leaves it
    chk("R9 flag held", {31'h0, sse_flag}, 32'h1);
    wr_reg(3'd7, 32'h0);
    chk("R9 zero write keeps flag", {31'h0, sse_flag}, 32'h1);
    wr_reg(3'd7, 32'h1);
    chk("R9 flag cleared", {31'h0, sse_flag}, 32'h0);

    // R6 masked types log (R4) but stay silent
    clear_all();
    for (int a = 3; a < 7; a++) wr_reg(3'(a), 32'h0);
    wr_reg(3'd4, 32'hFF);
    wr_reg(3'd2, 32'hFF);
    fire(8'hFF);
    chk("R6 masked silent", {28'h0, pulses()}, 32'h0);
    rd_reg(3'd0, d); chk("R4 masked still logged", d, 32'hFF00_0000);

    // R11 several types in one cycle combine per output
    clear_all();
    wr_reg(3'd4, 32'h22);
    wr_reg(3'd5, 32'h08);
    wr_reg(3'd2, 32'h00);
    fire(8'h2A);
    chk("R11 OR per output", {28'h0, pulses()}, 32'h3);
    tick();

    // R10 zero write keeps log, one-write clears selected bits only
    wr_reg(3'd0, 32'h0);
    rd_reg(3'd0, d); chk("R10 zero write no effect", d, 32'h2A00_0000);
    wr_reg(3'd0, 32'h0800_0000);
    rd_reg(3'd0, d); chk("R10 partial clear", d, 32'h2200_0000);
    tick();
    fire(8'h08);
    chk("R10 relog pulses again", {28'h0, pulses()}, 32'h1);
    tick();

    // R10 event in the clearing cycle moves to the repeat log
    reg_wr = 1'b1; reg_addr = 3'd0; reg_wdata = 32'h0200_0000;
    err_evt = 8'h02;
    tick();
    reg_wr = 1'b0; err_evt = '0;
    rd_reg(3'd0, d); chk("R10 clear with event: first", d, 32'h2800_0000);
    rd_reg(3'd1, d); chk("R10 clear with event: next", d, 32'h0200_0000);
    chk("R10 no pulse while combined held", {28'h0, pulses()}, 32'h0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule